// File: doc/BRIEF.md
# Conversion Start and Auto-Trigger Controller

This block decides when a sample conversion begins and how long it lasts. Software launches one conversion by pulsing a start request. The busy output then reads one for the whole conversion, and the block clears it by itself at the end. The analog core is modelled by a fixed-length counter of 13 prescaled clock periods. The prescaler divides the system clock by 2^k, where k comes from a 3-bit code.

With auto-triggering enabled, a 3-bit select chooses a trigger. Values 1 to 7 pick an external trigger input. The trigger inputs are synchronised, and each one has its own edge detector. A rising edge on the chosen input starts a conversion and restarts the prescaler from zero. Select value 0 chooses the completion flag instead, which gives free-running operation: software starts the first conversion, and from then on every completion starts the next one straight away.

A channel number written while a conversion runs is held back and applied only when that conversion ends. The completion flag sets whether or not its interrupt is enabled.

Top module: `conv_start_ctrl`

## Requirements
- R1: A one-cycle `sw_start` while idle raises `busy` after the next clock edge. `busy` stays high for exactly 13*2^k cycles, then clears by itself. k is `pre_code`, except that a code of 0 acts as 1.
- R2: Every start resets the prescaler, so the conversion length does not depend on when the start arrives relative to earlier prescaler ticks.
- R3: With `auto_en`=1 and `trig_sel`=s (1..7), a rising edge on `trig_in[s-1]` starts a conversion. `busy` rises at the third clock edge after the input changes. Edges on sources that are not selected start nothing.
- R4: A trigger edge that arrives while `busy` is high is ignored. The running conversion keeps its length, and no second conversion follows it.
- R5: If the selected trigger is still high when a conversion completes, no new conversion starts. A fresh rising edge is needed.
- R6: With `auto_en`=1 and `trig_sel`=0, nothing starts until `sw_start`. After that, conversions run back to back with `busy` held high, even if `done_flag` is never cleared. `conv_done` pulses once every 13*2^k cycles.
- R7: A channel written with `ch_wr` while idle appears on `ch_active` after one clock edge. A channel written during a conversion appears only once that conversion completes.
- R8: `done_flag` sets at every completion, whatever the value of `irq_en`. `irq` = `done_flag` AND `irq_en`. `flag_clr` clears the flag, but a completion in the same cycle wins.
- R9: Setting `auto_en` or changing `trig_sel` while trigger inputs are already high starts no conversion.
- R10: After reset, `busy`, `done_flag`, `irq`, `conv_done` and `ch_active` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start request, one cycle |
| auto_en | input | 1 | Enables auto-triggering |
| trig_sel | input | 3 | Trigger select: 0 = completion flag, s = trig_in[s-1] |
| trig_in | input | 7 | Asynchronous external trigger sources |
| pre_code | input | 3 | Prescaler code k, divide by 2^k |
| ch_wr | input | 1 | Channel write strobe |
| ch_in | input | 3 | Channel number to write |
| irq_en | input | 1 | Completion interrupt enable |
| flag_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | Conversion in progress (start bit readback) |
| conv_done | output | 1 | One-cycle completion pulse |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |
| ch_active | output | 3 | Channel used by the conversion |
| pre_tick | output | 1 | Prescaled clock tick |

## Verification
The hardest case to reach is a trigger edge that lands inside a running conversion, together with a trigger that is still high when the conversion completes. The bench holds a selected source high across the whole conversion. In a separate run it drops the source and raises it again partway through. In both cases it measures the exact busy length and then confirms that the block stays idle afterwards. Free-running mode is driven for three back-to-back conversions with the flag never cleared, and the bench counts the completion pulses while busy stays high.

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl #(
  parameter int NSRC       = 8,
  parameter int SEL_W      = $clog2(NSRC),
  parameter int CONV_TICKS = 13,
  parameter int CODE_W     = 3,
  parameter int CH_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_start,
  input  logic              auto_en,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [NSRC-2:0]   trig_in,
  input  logic [CODE_W-1:0] pre_code,
  input  logic              ch_wr,
  input  logic [CH_W-1:0]   ch_in,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              busy,
  output logic              conv_done,
  output logic              done_flag,
  output logic              irq,
  output logic [CH_W-1:0]   ch_active,
  output logic              pre_tick
);
  localparam int PRE_W  = (1 << CODE_W) - 1;
  localparam int TCNT_W = $clog2(CONV_TICKS);

  logic [NSRC-2:0]   sync1, sync2, prev;
  logic [NSRC-2:0]   edges;
  logic              sel_edge, free_mode, last, start, restart;
  logic [CODE_W-1:0] eff_code;
  logic [PRE_W-1:0]  pcnt, div_last;
  logic [TCNT_W-1:0] tcnt;
  logic [CH_W-1:0]   ch_pend;

  assign edges = sync2 & ~prev;

  always_comb begin
    sel_edge = 1'b0;
    for (int i = 1; i < NSRC; i++)
      if (trig_sel == SEL_W'(i)) sel_edge = edges[i-1];
  end

  assign eff_code = (pre_code == '0) ? CODE_W'(1) : pre_code;

  always_comb
    for (int i = 0; i < PRE_W; i++) div_last[i] = (i < int'(eff_code));

  assign free_mode = auto_en && (trig_sel == '0);
  assign pre_tick  = (pcnt == div_last);
  assign last      = (tcnt == TCNT_W'(CONV_TICKS - 1));
  assign conv_done = busy && pre_tick && last;
  assign restart   = conv_done && free_mode;
  assign start     = !busy && (sw_start || (auto_en && sel_edge));
  assign irq       = done_flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= trig_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      tcnt      <= '0;
      busy      <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      pcnt <= (start || restart || pre_tick) ? '0 : pcnt + 1'b1;
      if (start) begin
        busy <= 1'b1;
        tcnt <= '0;
      end else begin
        if (conv_done) busy <= restart;
        if (busy && pre_tick) tcnt <= last ? '0 : tcnt + 1'b1;
      end
      if (conv_done)     done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_pend   <= '0;
      ch_active <= '0;
    end else begin
      if (ch_wr) ch_pend <= ch_in;
      if (!busy)          ch_active <= ch_wr ? ch_in : ch_pend;
      else if (conv_done) ch_active <= ch_pend;
    end
  end
endmodule

module conv_start_ctrl_chk #(
  parameter int SEL_W = 3,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             conv_done,
  input logic             done_flag,
  input logic             auto_en,
  input logic [SEL_W-1:0] trig_sel,
  input logic [CH_W-1:0]  ch_active
);
  assert_busy_ends_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(conv_done));
  assert_no_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> busy);
  assert_stop_unless_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !(auto_en && trig_sel == '0) |=> !busy);
  assert_free_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && auto_en && trig_sel == '0 |=> busy);
  assert_channel_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> $stable(ch_active));
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_flag);
endmodule

bind conv_start_ctrl conv_start_ctrl_chk #(.SEL_W(SEL_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .conv_done(conv_done),
  .done_flag(done_flag), .auto_en(auto_en), .trig_sel(trig_sel),
  .ch_active(ch_active));

// File: tb/conv_start_ctrl_tb_top.sv
`timescale 1ns/1ps
module conv_start_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 0, auto_en = 0, ch_wr = 0, irq_en = 0, flag_clr = 0;
  logic [2:0] trig_sel = 0, pre_code = 0, ch_in = 0;
  logic [6:0] trig_in = 0;
  logic busy, conv_done, done_flag, irq, pre_tick;
  logic [2:0] ch_active;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  conv_start_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .auto_en(auto_en),
    .trig_sel(trig_sel), .trig_in(trig_in), .pre_code(pre_code),
    .ch_wr(ch_wr), .ch_in(ch_in), .irq_en(irq_en), .flag_clr(flag_clr),
    .busy(busy), .conv_done(conv_done), .done_flag(done_flag), .irq(irq),
    .ch_active(ch_active), .pre_tick(pre_tick));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_sw(output int n);
    sw_start = 1; nxt(); sw_start = 0;
    n = 0;
    while (busy) begin n++; nxt(); end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; nxt(); end
  endtask

  function automatic int len(input int code);
    return 13 * (1 << ((code == 0) ? 1 : code));
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, cnt;
    nxt(3); rst_n = 1; nxt();
    check(!busy && !done_flag && !irq && !conv_done && ch_active == 0,
          "R10 reset state", {busy, done_flag, irq, conv_done}, 0);

    for (int code = 0; code < 8; code++) begin
      pre_code = 3'(code);
      run_sw(n);
      check(n == len(code), "R1 software conversion length", n, len(code));
      check(done_flag && !irq, "R8 flag set with irq disabled", {done_flag, irq}, 2);
      flag_clr = 1; nxt(); flag_clr = 0;
    end

    pre_code = 3;
    for (int off = 0; off < 8; off++) begin
      nxt(off);
      run_sw(n);
      check(n == 104, "R2 length independent of start phase", n, 104);
    end

    pre_code = 1; auto_en = 1;
    for (int s = 1; s < 8; s++) begin
      trig_sel = 3'(s);
      for (int o = 0; o < 7; o++) if (o != s - 1) trig_in[o] = 1'b1;
      nxt(5);
      check(!busy, "R3 unselected sources ignored", busy, 0);
      trig_in = 0; nxt(4);
      trig_in[s-1] = 1'b1;
      nxt(); check(!busy, "R3 no start after one edge", busy, 0);
      nxt(); check(!busy, "R3 no start after two edges", busy, 0);
      nxt(); check(busy, "R3 start on selected edge", busy, 1);
      trig_in = 0;
      count_busy(n);
      check(n == 26, "R3 triggered conversion length", n, 26);
      nxt(4);
    end

    trig_sel = 2; trig_in[1] = 1; nxt(3); trig_in[1] = 0;
    n = 0;
    while (busy) begin
      n++;
      if (n == 8) trig_in[1] = 1;
      if (n == 10) trig_in[1] = 0;
      nxt();
    end
    check(n == 26, "R4 edge during busy keeps length", n, 26);
    nxt(10);
    check(!busy, "R4 no conversion after ignored edge", busy, 0);

    trig_in[1] = 1; nxt(3);
    check(busy, "R5 start before hold", busy, 1);
    count_busy(n);
    nxt(20);
    check(!busy, "R5 held trigger does not restart", busy, 0);
    trig_in[1] = 0; nxt(3); trig_in[1] = 1; nxt(3);
    check(busy, "R5 fresh edge restarts", busy, 1);
    count_busy(n);
    trig_in = 0; nxt(4);

    auto_en = 0; trig_in = '1; nxt(5);
    auto_en = 1; nxt();
    for (int s = 1; s < 8; s++) begin
      trig_sel = 3'(s); nxt();
    end
    nxt(3);
    check(!busy, "R9 enable and select change no start", busy, 0);
    trig_in = 0; nxt(5);

    flag_clr = 1; nxt(); flag_clr = 0;
    trig_sel = 0; auto_en = 1; nxt(40);
    check(!busy, "R6 free mode waits for software start", busy, 0);
    sw_start = 1; nxt(); sw_start = 0;
    cnt = 0; n = 0;
    for (int i = 1; i <= 78; i++) begin
      if (busy) n++;
      if (conv_done) cnt++;
      if (i < 78) nxt();
    end
    check(n == 78, "R6 busy held through chain", n, 78);
    check(cnt == 3, "R6 completion pulses in chain", cnt, 3);
    check(done_flag, "R6 flag left set during chain", done_flag, 1);
    nxt();
    check(busy, "R6 chain continues with flag set", busy, 1);
    auto_en = 0;
    count_busy(n);
    nxt(3);
    check(!busy, "R6 chain stops when auto disabled", busy, 0);

    ch_in = 5; ch_wr = 1; nxt(); ch_wr = 0;
    check(ch_active == 5, "R7 idle channel write", ch_active, 5);
    sw_start = 1; nxt(); sw_start = 0;
    nxt(5);
    ch_in = 3; ch_wr = 1; nxt(); ch_wr = 0;
    check(ch_active == 5, "R7 channel held during conversion", ch_active, 5);
    nxt(10);
    check(ch_active == 5, "R7 channel still held", ch_active, 5);
    count_busy(n);
    check(ch_active == 3, "R7 channel applied after completion", ch_active, 3);

    flag_clr = 1; nxt(); flag_clr = 0;
    check(!done_flag, "R8 flag clear", done_flag, 0);
    irq_en = 0;
    run_sw(n);
    check(done_flag && !irq, "R8 flag without irq", {done_flag, irq}, 2);
    irq_en = 1; nxt();
    check(irq, "R8 irq when enabled", irq, 1);
    flag_clr = 1;
    run_sw(n);
    check(done_flag, "R8 completion beats clear", done_flag, 1);
    nxt();
    check(!done_flag && !irq, "R8 clear after completion", {done_flag, irq}, 0);
    flag_clr = 0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule